// File: doc/BRIEF.md
# Indexed Socket Memory-Window Translator

This block sits on the host side of a two-socket card controller. Software reaches its register space through two byte-wide ports. A write to the pointer port loads an 8-bit index. The data port then reads or writes the byte that the index names. The two upper index bits pick a socket, and the six lower bits pick one of 64 byte locations in that socket's bank.

Each socket has five memory windows. A window is a page range of the 24-bit host address space, with 4 KB pages, and it carries a card-side page offset and a few cycle attributes. On every host memory request the block compares the request page with the enabled windows of the addressed socket. One clock later it presents the result: hit, translated card address, attribute/common select, bus width, wait-state hints and write protection. A write that lands in a protected window is flagged so that the cycle logic can drop it.

Top module: `win_xlate`

## Requirements
- R1: After reset every register is zero, the pointer reads 0 and all translation outputs are 0.
- R2: A write with `reg_sel`=0 loads `reg_wdata` into the pointer, and a read with `reg_sel`=0 returns the pointer.
- R3: Pointer bits 7:6 select the socket. Sockets 2 and 3 do not exist, so they read 0 and ignore writes. Sockets 0 and 1 hold independent banks.
- R4: Location 0x00 of a present socket reads the identification byte 0x83 and ignores writes.
- R5: Location 0x06 is the window enable byte. Bit w enables window w (bits 4:0). Bits 7:5 read 0.
- R6: Window w occupies locations 0x10+8w to 0x10+8w+5, holding start low, start high, end low, end high, offset low and offset high in that order. Each low byte gives page bits 7:0 and each high byte gives page bits 11:8 in its bits 3:0. Start-high bit 7 selects 16-bit width and bit 6 selects zero wait. End-high bits 7:6 give the wait count. Offset-high bit 7 write-protects the window and bit 6 selects attribute space. Bits 5:4 of every high byte read 0.
- R7: The two spare bytes of each window (+6, +7) and every other location read 0 and ignore writes.
- R8: A window hits when `mem_req` is 1, the window is enabled, and host address bits 23:12 lie between its start and end, both included. Results appear one clock after the request.
- R9: When several windows hit, the lowest-numbered one is reported.
- R10: `card_addr` bits 23:12 are the request page plus the window offset, modulo 4096. Bits 11:0 equal the host address bits 11:0.
- R11: On a hit, `card_wide`, `card_zero_wait`, `card_wait`, `card_attr` and `card_wp` carry the winning window's flags. Without a hit, all translation outputs are 0.
- R12: `wr_blocked` is 1 exactly when a hit occurs for a request with `mem_write`=1 on a write-protected window.
- R13: `mem_sock` selects whose windows are searched. The other socket's windows have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register port write strobe |
| reg_sel | input | 1 | 0 = pointer port, 1 = data port |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Pointer or selected byte (combinational) |
| mem_req | input | 1 | Host memory request valid |
| mem_write | input | 1 | Request is a write |
| mem_sock | input | 1 | Socket addressed by the request |
| mem_addr | input | 24 | Host memory address |
| mem_hit | output | 1 | A window matched |
| card_addr | output | 24 | Translated card address |
| card_wide | output | 1 | 16-bit data width |
| card_zero_wait | output | 1 | Zero-wait request |
| card_wait | output | 2 | Wait-state count |
| card_attr | output | 1 | 1 = attribute space, 0 = common space |
| card_wp | output | 1 | Window is write-protected |
| wr_blocked | output | 1 | Write suppressed by protection |

## Verification
Register writes take effect at the clock edge that samples the strobe. Because the data port is read combinationally, a readback is sampled on the falling edge right after that write edge. A translation request is driven on a falling edge and registered on the next rising edge, so every translation output is compared on the falling edge that follows: one clock after the request. The bench keeps its own byte image of both banks. From that image it computes the expected readback for every location and the expected translation for every request. It therefore never compares two results in the same cycle that are due in different cycles.

// File: rtl/win_pkg.sv
package win_pkg;
    localparam int HOST_AW     = 24;
    localparam int PAGE_LSB    = 12;
    localparam int PAGE_W      = HOST_AW - PAGE_LSB;
    localparam int WIN_BYTES   = 6;
    localparam int WIN_STRIDE  = 8;
    localparam logic [5:0] WIN_BASE = 6'h10;
    localparam logic [5:0] EN_LOC   = 6'h06;
    localparam logic [5:0] ID_LOC   = 6'h00;
    localparam int FLAG_HI     = 7;
    localparam int FLAG_LO     = 6;

    typedef struct packed {
        logic               hit;
        logic [HOST_AW-1:0] card_addr;
        logic               wide;
        logic               zws;
        logic [1:0]         ws;
        logic               attr;
        logic               wp;
        logic               blocked;
    } xlate_t;

    // odd window bytes are high bytes: bits 5:4 unused
    function automatic logic [7:0] byte_mask(input int k);
        return (k % 2 == 1) ? 8'hCF : 8'hFF;
    endfunction
endpackage

// File: rtl/win_regbank.sv
module win_regbank
    import win_pkg::*;
#(
    parameter int         NSOCK   = 2,
    parameter int         NWIN    = 5,
    parameter logic [7:0] ID_BYTE = 8'h83
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reg_we,
    input  logic reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [NSOCK-1:0][NWIN-1:0][WIN_BYTES-1:0][7:0] bank_bytes,
    output logic [NSOCK-1:0][NWIN-1:0] bank_en
);
    localparam logic [7:0] EN_MASK = 8'((1 << NWIN) - 1);

    typedef struct packed {
        logic [7:0] idx;
        logic [NSOCK-1:0][NWIN-1:0] en;
        logic [NSOCK-1:0][NWIN-1:0][WIN_BYTES-1:0][7:0] bytes;
    } bank_t;

    bank_t st_d, st_q;
    logic [1:0] sock_f;
    logic [5:0] loc_f;
    logic       tgt_ok;

    assign sock_f = st_q.idx[7:6];
    assign loc_f  = st_q.idx[5:0];

    always_comb begin
        st_d      = st_q;
        tgt_ok    = 1'b0;
        reg_rdata = 8'h00;
        for (int s = 0; s < NSOCK; s++) begin
            if (sock_f == 2'(s)) begin
                if (loc_f == ID_LOC) reg_rdata = ID_BYTE;
                if (loc_f == EN_LOC) begin
                    tgt_ok    = 1'b1;
                    reg_rdata = 8'(st_q.en[s]);
                    if (reg_we && reg_sel) st_d.en[s] = NWIN'(reg_wdata & EN_MASK);
                end
                for (int w = 0; w < NWIN; w++) begin
                    for (int k = 0; k < WIN_BYTES; k++) begin
                        if (loc_f == 6'(int'(WIN_BASE) + WIN_STRIDE * w + k)) begin
                            tgt_ok    = 1'b1;
                            reg_rdata = st_q.bytes[s][w][k];
                            if (reg_we && reg_sel)
                                st_d.bytes[s][w][k] = reg_wdata & byte_mask(k);
                        end
                    end
                end
            end
        end
        if (!reg_sel) reg_rdata = st_q.idx;
        if (reg_we && !reg_sel) st_d.idx = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank_bytes = st_q.bytes;
    assign bank_en    = st_q.en;

    assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_sel) |=> (st_q.idx == $past(reg_wdata)));
    assert_spare_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel && !tgt_ok) |=> ($stable(st_q.bytes) && $stable(st_q.en)));
    assert_absent_socket_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel && (int'(sock_f) >= NSOCK)) |=> ($stable(st_q.bytes) && $stable(st_q.en)));
endmodule

// File: rtl/win_lookup.sv
module win_lookup
    import win_pkg::*;
#(
    parameter int NWIN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic write,
    input  logic [HOST_AW-1:0] addr,
    input  logic [NWIN-1:0][WIN_BYTES-1:0][7:0] win_bytes,
    input  logic [NWIN-1:0] win_en,
    output xlate_t res
);
    xlate_t res_d, res_q;

    always_comb begin
        logic              found;
        logic [PAGE_W-1:0] page, lo, hi, off, mapped;
        res_d  = '0;
        found  = 1'b0;
        page   = addr[HOST_AW-1:PAGE_LSB];
        for (int w = 0; w < NWIN; w++) begin
            lo     = {win_bytes[w][1][3:0], win_bytes[w][0]};
            hi     = {win_bytes[w][3][3:0], win_bytes[w][2]};
            off    = {win_bytes[w][5][3:0], win_bytes[w][4]};
            mapped = page + off;
            if (!found && req && win_en[w] && page >= lo && page <= hi) begin
                found           = 1'b1;
                res_d.hit       = 1'b1;
                res_d.card_addr = {mapped, addr[PAGE_LSB-1:0]};
                res_d.wide      = win_bytes[w][1][FLAG_HI];
                res_d.zws       = win_bytes[w][1][FLAG_LO];
                res_d.ws        = win_bytes[w][3][FLAG_HI:FLAG_LO];
                res_d.wp        = win_bytes[w][5][FLAG_HI];
                res_d.attr      = win_bytes[w][5][FLAG_LO];
                res_d.blocked   = write & win_bytes[w][5][FLAG_HI];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res = res_q;

    assert_idle_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req) |-> !res_q.hit);
    assert_low_bits_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_q.hit |-> (res_q.card_addr[PAGE_LSB-1:0] == $past(addr[PAGE_LSB-1:0])));
    assert_block_needs_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        res_q.blocked |-> ($past(write) && res_q.wp && res_q.hit));
    assert_quiet_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_q.hit |-> (res_q.card_addr == '0 && !res_q.wp && !res_q.attr && res_q.ws == 2'b00));
endmodule

// File: rtl/win_xlate.sv
module win_xlate
    import win_pkg::*;
#(
    parameter int         NSOCK   = 2,
    parameter int         NWIN    = 5,
    parameter logic [7:0] ID_BYTE = 8'h83,
    localparam int        SW      = (NSOCK > 1) ? $clog2(NSOCK) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reg_we,
    input  logic reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic mem_req,
    input  logic mem_write,
    input  logic [SW-1:0] mem_sock,
    input  logic [HOST_AW-1:0] mem_addr,
    output logic mem_hit,
    output logic [HOST_AW-1:0] card_addr,
    output logic card_wide,
    output logic card_zero_wait,
    output logic [1:0] card_wait,
    output logic card_attr,
    output logic card_wp,
    output logic wr_blocked
);
    logic [NSOCK-1:0][NWIN-1:0][WIN_BYTES-1:0][7:0] bank_bytes;
    logic [NSOCK-1:0][NWIN-1:0] bank_en;
    logic [NWIN-1:0][WIN_BYTES-1:0][7:0] sel_bytes;
    logic [NWIN-1:0] sel_en;
    xlate_t res;

    win_regbank #(.NSOCK(NSOCK), .NWIN(NWIN), .ID_BYTE(ID_BYTE)) u_bank (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bank_bytes(bank_bytes), .bank_en(bank_en)
    );

    always_comb begin
        sel_bytes = '0;
        sel_en    = '0;
        for (int s = 0; s < NSOCK; s++) begin
            if (mem_sock == SW'(s)) begin
                sel_bytes = bank_bytes[s];
                sel_en    = bank_en[s];
            end
        end
    end

    win_lookup #(.NWIN(NWIN)) u_look (
        .clk(clk), .rst_n(rst_n), .req(mem_req), .write(mem_write),
        .addr(mem_addr), .win_bytes(sel_bytes), .win_en(sel_en), .res(res)
    );

    assign mem_hit        = res.hit;
    assign card_addr      = res.card_addr;
    assign card_wide      = res.wide;
    assign card_zero_wait = res.zws;
    assign card_wait      = res.ws;
    assign card_attr      = res.attr;
    assign card_wp        = res.wp;
    assign wr_blocked     = res.blocked;
endmodule

// File: tb/win_xlate_tb_top.sv
module win_xlate_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic mem_req = 1'b0, mem_write = 1'b0;
    logic [0:0] mem_sock = 1'b0;
    logic [23:0] mem_addr = 24'h0;
    logic mem_hit, card_wide, card_zero_wait, card_attr, card_wp, wr_blocked;
    logic [23:0] card_addr;
    logic [1:0] card_wait;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [0:3][0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    win_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_write(mem_write), .mem_sock(mem_sock), .mem_addr(mem_addr),
        .mem_hit(mem_hit), .card_addr(card_addr), .card_wide(card_wide),
        .card_zero_wait(card_zero_wait), .card_wait(card_wait),
        .card_attr(card_attr), .card_wp(card_wp), .wr_blocked(wr_blocked)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] idx);
        if (idx[7:6] >= 2) return 8'h00;
        if (idx[5:0] == 6'h00) return 8'h83;
        return mdl[idx[7:6]][idx[5:0]];
    endfunction

    function automatic void mdl_wr(input logic [7:0] idx, input logic [7:0] v);
        int s = int'(idx[7:6]);
        int r = int'(idx[5:0]);
        if (s >= 2) return;
        if (r == 6) mdl[s][r] = v & 8'h1F;
        else if (r >= 16 && r < 56 && (r % 8) < 6)
            mdl[s][r] = v & (((r % 8) % 2 == 1) ? 8'hCF : 8'hFF);
    endfunction

    // {hit, card_addr, wide, zws, ws, attr, wp, blocked}
    function automatic logic [31:0] exp_look(input int s, input logic [23:0] a,
                                             input logic wr, input logic rq);
        logic [11:0] pg = a[23:12];
        for (int w = 0; w < 5; w++) begin
            int b = 16 + 8 * w;
            logic [11:0] lo = {mdl[s][b+1][3:0], mdl[s][b]};
            logic [11:0] hi = {mdl[s][b+3][3:0], mdl[s][b+2]};
            logic [11:0] off = {mdl[s][b+5][3:0], mdl[s][b+4]};
            logic [11:0] cp = pg + off;
            if (rq && mdl[s][6][w] && pg >= lo && pg <= hi)
                return {1'b1, cp, a[11:0], mdl[s][b+1][7], mdl[s][b+1][6],
                        mdl[s][b+3][7:6], mdl[s][b+5][6], mdl[s][b+5][7],
                        wr & mdl[s][b+5][7]};
        end
        return 32'h0;
    endfunction

    function automatic logic [31:0] dut_look();
        return {mem_hit, card_addr, card_wide, card_zero_wait, card_wait,
                card_attr, card_wp, wr_blocked};
    endfunction

    task automatic port_wr(input logic sel, input logic [7:0] v);
        @(negedge clk);
        reg_sel = sel; reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] v);
        port_wr(1'b0, idx);
        port_wr(1'b1, v);
        mdl_wr(idx, v);
    endtask

    task automatic reg_chk(input logic [7:0] idx, input string tag);
        port_wr(1'b0, idx);
        reg_sel = 1'b1;
        #1;
        check({24'h0, reg_rdata}, {24'h0, exp_rd(idx)}, tag);
    endtask

    task automatic look(input int s, input logic [23:0] a, input logic wr,
                        input logic rq, input string tag);
        @(negedge clk);
        mem_sock = 1'(s); mem_addr = a; mem_write = wr; mem_req = rq;
        @(negedge clk);
        #1;
        check(dut_look(), exp_look(s, a, wr, rq), tag);
        mem_req = 1'b0;
    endtask

    task automatic set_win(input int s, input int w, input logic [11:0] lo,
                           input logic [11:0] hi, input logic [11:0] off,
                           input logic [3:0] lo_f, input logic [3:0] hi_f,
                           input logic [3:0] off_f);
        logic [7:0] b = 8'(s * 64 + 16 + 8 * w);
        reg_wr(b,     lo[7:0]);
        reg_wr(b + 1, {lo_f, lo[11:8]});
        reg_wr(b + 2, hi[7:0]);
        reg_wr(b + 3, {hi_f, hi[11:8]});
        reg_wr(b + 4, off[7:0]);
        reg_wr(b + 5, {off_f, off[11:8]});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++)
            for (int r = 0; r < 64; r++) mdl[s][r] = 8'h00;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check({24'h0, reg_rdata}, 32'h0, "R1 pointer after reset");
        check(dut_look(), 32'h0, "R1 outputs after reset");
        reg_chk(8'h06, "R1 enable byte after reset");
        reg_chk(8'h13, "R1 window byte after reset");
        // R2 pointer readback
        port_wr(1'b0, 8'hA5);
        reg_sel = 1'b0; #1;
        check({24'h0, reg_rdata}, 32'hA5, "R2 pointer readback");
        // R4 identification
        reg_chk(8'h00, "R4 id byte");
        reg_wr(8'h40, 8'h11);
        reg_chk(8'h40, "R4 id after write socket 1");
        // R5 enable mask
        reg_wr(8'h06, 8'hFF);
        reg_chk(8'h06, "R5 enable upper bits zero");
        reg_wr(8'h06, 8'h00);
        // R6 masked high byte
        reg_wr(8'h11, 8'hFF);
        reg_chk(8'h11, "R6 start high reserved bits");
        reg_wr(8'h11, 8'h00);
        // R7 spare and unimplemented
        reg_wr(8'h16, 8'hFF);
        reg_chk(8'h16, "R7 spare byte");
        reg_wr(8'h3A, 8'h77);
        reg_chk(8'h3A, "R7 unimplemented location");
        reg_wr(8'h07, 8'h55);
        reg_chk(8'h07, "R7 location 0x07");
        // R3 absent and independent sockets
        reg_wr(8'h90, 8'h3C);
        reg_chk(8'h90, "R3 absent socket");
        reg_wr(8'h50, 8'h9A);
        reg_chk(8'h10, "R3 socket 0 untouched");
        reg_chk(8'h50, "R3 socket 1 byte");

        // directed windows on socket 0
        set_win(0, 0, 12'h100, 12'h1FF, 12'h050, 4'b1000, 4'b0100, 4'b0000);
        set_win(0, 1, 12'h180, 12'h2FF, 12'hF00, 4'b0100, 4'b1100, 4'b1100);
        set_win(0, 3, 12'h800, 12'h800, 12'h001, 4'b0000, 4'b0000, 4'b0000);
        reg_wr(8'h06, 8'h03);
        look(0, 24'h100ABC, 1'b0, 1'b1, "R8 start page inclusive");
        look(0, 24'h0FFFFF, 1'b0, 1'b1, "R8 below start");
        look(0, 24'h2FF123, 1'b0, 1'b1, "R8 end page inclusive");
        look(0, 24'h300000, 1'b0, 1'b1, "R8 above end");
        look(0, 24'h150000, 1'b0, 1'b0, "R8 request low");
        look(0, 24'h800000, 1'b0, 1'b1, "R8 disabled window");
        look(0, 24'h180456, 1'b0, 1'b1, "R9 lowest window wins");
        look(0, 24'h250FFF, 1'b0, 1'b1, "R10 offset wraps");
        look(0, 24'h1FF001, 1'b0, 1'b1, "R11 flags window 0");
        look(0, 24'h210000, 1'b1, 1'b1, "R12 protected write");
        look(0, 24'h210000, 1'b0, 1'b1, "R12 protected read");
        look(0, 24'h120000, 1'b1, 1'b1, "R12 unprotected write");
        look(1, 24'h150000, 1'b0, 1'b1, "R13 socket 1 empty");
        reg_wr(8'h06, 8'h0B);
        look(0, 24'h800FED, 1'b0, 1'b1, "R8 single page window");

        // random register traffic and lookups
        for (int i = 0; i < 400; i++) begin
            logic [7:0] idx = 8'($urandom);
            if (i % 2 == 0) idx = {1'b0, 1'($urandom), 6'(16 + ($urandom % 40))};
            reg_wr(idx, 8'($urandom));
            if (i % 4 == 0) reg_chk(8'($urandom), "R6 random readback");
        end
        for (int s = 0; s < 2; s++) reg_wr(8'(s * 64 + 6), 8'h1F);
        for (int i = 0; i < 600; i++) begin
            int s = int'($urandom % 2);
            look(s, 24'($urandom), 1'($urandom), ($urandom % 8) != 0,
                 "R10 random translation");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule